// File: doc/BRIEF.md
# Pipelined Unibit-Trie Route Lookup

The block resolves a 32-bit destination address to a next-hop index by longest-prefix match. The address's top bits choose one of several parallel lookup pipelines. The remaining bits then steer a walk through a unibit trie. The trie's nodes are spread over the stages of the chosen pipeline, and each stage owns a small node memory.

A node's children may be placed in any later stage. Each request in flight therefore carries the stage and address of the node it needs next. A stage holding a different node passes the request through untouched. The result is the next-hop index of the deepest node on the path that carries one, or a miss flag when none does.

Table contents are loaded through a single node write port addressed by pipeline, stage and node slot. Lookups are accepted every cycle. Each result appears on the output lane of its pipeline a fixed number of cycles later.

Top module: `trie_lkp_pipeline`

## Requirements
- R1: The top SEL_W address bits (bits 31:30 by default) pick the pipeline. Only that pipeline's `res_valid` bit rises for the request, and at most one `res_valid` bit is high in any cycle.
- R2: A lookup presented before clock edge k gives its result just after edge k+N_STAGES, which is N_STAGES+1 edges in all. Results leave in request order, and back-to-back lookups are each answered.
- R3: The walk starts at the root, which is node slot 0 of stage 0. At each visited node it uses the next address bit, taking bit 29 first and moving toward bit 0. A 0 selects the left child and a 1 selects the right child.
- R4: A node's children pointer gives a target stage and a base slot. The left child sits at the base. The right child sits at base+1 when the left child exists, and at base+0 when it does not.
- R5: A child may sit in any later stage. Stages between the parent and the child neither read their memory nor change the request, so a node stored in a skipped stage never affects the result.
- R6: Every visited node whose next-hop-present bit is set replaces the pending next-hop index. The deepest such node on the path gives the answer.
- R7: The walk ends at a node whose child-exists bit for the current direction is clear. It also ends when the next target stage lies at or before the current one, and when all 30 walk bits have been used. Nodes after the end are never consulted.
- R8: If no visited node carries a next hop, the result has `res_miss`=1 and `res_nh`=0.
- R9: A node write lands in the addressed pipeline, stage and slot on the clock edge where `wr_en` is sampled high. Lookups presented afterwards see the new contents. Other pipelines are unaffected.
- R10: After reset every node memory is empty and every `res_valid` bit is 0. A lookup made before any write returns a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lkp_valid | input | 1 | Lookup request valid this cycle |
| lkp_addr | input | 32 | Destination address to resolve |
| wr_en | input | 1 | Node write strobe |
| wr_pipe | input | 2 | Pipeline holding the written node |
| wr_stage | input | 2 | Stage holding the written node |
| wr_addr | input | 4 | Node slot within that stage |
| wr_nh_ok | input | 1 | Node carries a next hop |
| wr_left | input | 1 | Node has a left child |
| wr_right | input | 1 | Node has a right child |
| wr_child_stage | input | 2 | Stage of the node's children |
| wr_child_addr | input | 4 | Base slot of the node's children |
| wr_nh | input | 8 | Node's next-hop index |
| res_valid | output | 4 | One result-valid bit per pipeline |
| res_miss | output | 4 | One no-match flag per pipeline |
| res_nh | output | 32 | Next-hop index per pipeline, 8 bits each, pipeline p at bits 8p+7:8p |

## Verification
On every cycle the assertions check that the selector lights exactly one pipeline lane per accepted lookup and that the output lanes never overlap. They also check that a stage not addressed by a request forwards it bit for bit, that a next hop once found and a finished walk both stay set as the request moves down, and that the count of used walk bits never exceeds 30. Only the bench's scenarios can show the rest. Those are child placement at base+1 versus base+0, skipping a stage that holds a decoy node, the deepest next hop winning over a shallower one, and the walk stopping at a missing child. They also cover misses on empty pipelines, writes becoming visible to later lookups, and the exact result latency under back-to-back traffic.

// File: rtl/lkp_pkg.sv
package lkp_pkg;
    parameter int ADDR_W     = 32;
    parameter int SEL_W      = 2;
    parameter int N_PIPES    = 1 << SEL_W;
    parameter int N_STAGES   = 4;
    parameter int STG_W      = (N_STAGES > 1) ? $clog2(N_STAGES) : 1;
    parameter int NODE_AW    = 4;
    parameter int NODE_DEPTH = 1 << NODE_AW;
    parameter int NH_W       = 8;
    parameter int WALK_W     = ADDR_W - SEL_W;
    parameter int USED_W     = $clog2(WALK_W + 1);

    // One trie node as held in a stage memory
    typedef struct packed {
        logic               nh_ok;
        logic               left;
        logic               right;
        logic [STG_W-1:0]   cstage;
        logic [NODE_AW-1:0] caddr;
        logic [NH_W-1:0]    nh;
    } node_t;

    // One request travelling down a pipeline
    typedef struct packed {
        logic               valid;
        logic               done;
        logic [STG_W-1:0]   tstage;
        logic [NODE_AW-1:0] taddr;
        logic [WALK_W-1:0]  bits;
        logic [USED_W-1:0]  used;
        logic               hit;
        logic [NH_W-1:0]    nh;
    } req_t;
endpackage

// File: rtl/lkp_selector.sv
module lkp_selector
    import lkp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output req_t              out_req [N_PIPES]
);
    req_t req_d [N_PIPES];
    req_t req_q [N_PIPES];

    always_comb begin
        for (int p = 0; p < N_PIPES; p++) begin
            req_d[p]       = '0;
            req_d[p].valid = in_valid && (in_addr[ADDR_W-1 -: SEL_W] == SEL_W'(p));
            req_d[p].bits  = in_addr[WALK_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < N_PIPES; p++) req_q[p] <= '0;
        end else begin
            for (int p = 0; p < N_PIPES; p++) req_q[p] <= req_d[p];
        end
    end

    assign out_req = req_q;

    logic [N_PIPES-1:0] lane_vec;
    always_comb begin
        for (int p = 0; p < N_PIPES; p++) lane_vec[p] = req_q[p].valid;
    end

    assert_one_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> $countones(lane_vec) == 1);
    assert_idle_lanes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> lane_vec == '0);
endmodule

// File: rtl/lkp_stage.sv
module lkp_stage
    import lkp_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  req_t               in_req,
    input  logic               wr_en,
    input  logic [NODE_AW-1:0] wr_addr,
    input  node_t              wr_node,
    output req_t               out_req
);
    node_t mem_q [NODE_DEPTH];
    req_t  req_d, req_q;
    node_t node;
    logic  act;
    logic  dir;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NODE_DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_node;
        end
    end

    always_comb begin
        act   = in_req.valid && !in_req.done && (in_req.tstage == STG_W'(IDX));
        node  = act ? mem_q[in_req.taddr] : '0;
        dir   = in_req.bits[WALK_W-1];
        req_d = in_req;
        if (act) begin
            if (node.nh_ok) begin
                req_d.hit = 1'b1;
                req_d.nh  = node.nh;
            end
            if (in_req.used == USED_W'(WALK_W)) begin
                req_d.done = 1'b1;
            end else begin
                req_d.bits = in_req.bits << 1;
                req_d.used = in_req.used + 1'b1;
                if (!dir && node.left) begin
                    req_d.tstage = node.cstage;
                    req_d.taddr  = node.caddr;
                end else if (dir && node.right) begin
                    req_d.tstage = node.cstage;
                    req_d.taddr  = node.caddr + NODE_AW'(node.left);
                end else begin
                    req_d.done = 1'b1;
                end
                // a child must lie in a later stage
                if (!req_d.done && (int'(node.cstage) <= IDX)) req_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign out_req = req_q;

    assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> out_req == $past(in_req));
    assert_hit_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req.valid && in_req.hit) |=> out_req.hit);
    assert_done_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req.valid && in_req.done) |=> out_req.done);
    assert_bits_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_req.used <= USED_W'(WALK_W));
endmodule

// File: rtl/lkp_pipe.sv
module lkp_pipe
    import lkp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  req_t               in_req,
    input  logic               wr_en,
    input  logic [STG_W-1:0]   wr_stage,
    input  logic [NODE_AW-1:0] wr_addr,
    input  node_t              wr_node,
    output logic               res_valid,
    output logic               res_miss,
    output logic [NH_W-1:0]    res_nh
);
    req_t link [N_STAGES+1];

    assign link[0] = in_req;

    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
        lkp_stage #(.IDX(s)) stage_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_req  (link[s]),
            .wr_en   (wr_en && (wr_stage == STG_W'(s))),
            .wr_addr (wr_addr),
            .wr_node (wr_node),
            .out_req (link[s+1])
        );
    end

    assign res_valid = link[N_STAGES].valid;
    assign res_miss  = link[N_STAGES].valid && !link[N_STAGES].hit;
    assign res_nh    = link[N_STAGES].hit ? link[N_STAGES].nh : '0;
endmodule

// File: rtl/trie_lkp_pipeline.sv
module trie_lkp_pipeline
    import lkp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lkp_valid,
    input  logic [ADDR_W-1:0]       lkp_addr,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_pipe,
    input  logic [STG_W-1:0]        wr_stage,
    input  logic [NODE_AW-1:0]      wr_addr,
    input  logic                    wr_nh_ok,
    input  logic                    wr_left,
    input  logic                    wr_right,
    input  logic [STG_W-1:0]        wr_child_stage,
    input  logic [NODE_AW-1:0]      wr_child_addr,
    input  logic [NH_W-1:0]         wr_nh,
    output logic [N_PIPES-1:0]      res_valid,
    output logic [N_PIPES-1:0]      res_miss,
    output logic [N_PIPES*NH_W-1:0] res_nh
);
    req_t  sel_req [N_PIPES];
    node_t wr_node;

    always_comb begin
        wr_node.nh_ok  = wr_nh_ok;
        wr_node.left   = wr_left;
        wr_node.right  = wr_right;
        wr_node.cstage = wr_child_stage;
        wr_node.caddr  = wr_child_addr;
        wr_node.nh     = wr_nh;
    end

    lkp_selector sel_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (lkp_valid),
        .in_addr  (lkp_addr),
        .out_req  (sel_req)
    );

    for (genvar p = 0; p < N_PIPES; p++) begin : g_pipe
        lkp_pipe pipe_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_req    (sel_req[p]),
            .wr_en     (wr_en && (wr_pipe == SEL_W'(p))),
            .wr_stage  (wr_stage),
            .wr_addr   (wr_addr),
            .wr_node   (wr_node),
            .res_valid (res_valid[p]),
            .res_miss  (res_miss[p]),
            .res_nh    (res_nh[p*NH_W +: NH_W])
        );
    end

    assert_lanes_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(res_valid));
    assert_miss_zero_nh_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid[0] && res_miss[0]) |-> res_nh[NH_W-1:0] == '0);
endmodule

// File: tb/trie_lkp_pipeline_tb.sv
module trie_lkp_pipeline_tb_top;
    import lkp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = N_STAGES + 1;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    lkp_valid = 1'b0;
    logic [ADDR_W-1:0]       lkp_addr = '0;
    logic                    wr_en = 1'b0;
    logic [SEL_W-1:0]        wr_pipe = '0;
    logic [STG_W-1:0]        wr_stage = '0;
    logic [NODE_AW-1:0]      wr_addr = '0;
    logic                    wr_nh_ok = 1'b0;
    logic                    wr_left = 1'b0;
    logic                    wr_right = 1'b0;
    logic [STG_W-1:0]        wr_child_stage = '0;
    logic [NODE_AW-1:0]      wr_child_addr = '0;
    logic [NH_W-1:0]         wr_nh = '0;
    logic [N_PIPES-1:0]      res_valid;
    logic [N_PIPES-1:0]      res_miss;
    logic [N_PIPES*NH_W-1:0] res_nh;

    trie_lkp_pipeline dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int    pipe;
        bit    miss;
        int    nh;
        int    issue;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   running = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per result and compares it
    always @(negedge clk) begin
        if (running) begin
            for (int p = 0; p < N_PIPES; p++) begin
                if (res_valid[p]) begin
                    if (q.size() == 0) begin
                        check("R2 unexpected result", p, -1);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check({e.tag, " lane"}, p, e.pipe);
                        check({e.tag, " miss"}, int'(res_miss[p]), int'(e.miss));
                        check({e.tag, " next hop"}, int'(res_nh[p*NH_W +: NH_W]), e.nh);
                        check({e.tag, " R2 latency"}, cyc - e.issue, LATENCY);
                    end
                end
            end
        end
    end

    task automatic lookup(input logic [ADDR_W-1:0] addr, input bit miss,
                          input int nh, input string tag);
        exp_t e;
        @(negedge clk);
        lkp_valid = 1'b1;
        lkp_addr  = addr;
        e.pipe  = int'(addr[ADDR_W-1 -: SEL_W]);
        e.miss  = miss;
        e.nh    = nh;
        e.issue = cyc;
        e.tag   = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        lkp_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic wnode(input int p, input int s, input int a, input bit ok,
                         input bit l, input bit r, input int cs, input int ca,
                         input int nh);
        @(negedge clk);
        lkp_valid      = 1'b0;
        wr_en          = 1'b1;
        wr_pipe        = SEL_W'(p);
        wr_stage       = STG_W'(s);
        wr_addr        = NODE_AW'(a);
        wr_nh_ok       = ok;
        wr_left        = l;
        wr_right       = r;
        wr_child_stage = STG_W'(cs);
        wr_child_addr  = NODE_AW'(ca);
        wr_nh          = NH_W'(nh);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: outputs idle after reset
        check("R10 reset valid", int'(res_valid), 0);
        running = 1'b1;

        // R10 / R8: empty pipelines miss
        lookup({2'b00, 30'h2AAAAAAA}, 1'b1, 0, "R10 empty pipe0");
        lookup({2'b11, 30'h0}, 1'b1, 0, "R8 empty pipe3");
        idle(LATENCY + 2);

        // Trie in pipeline 1; stage 1 holds a decoy that must be skipped (R5)
        wnode(1, 0, 0, 1, 1, 1, 2, 4, 10);  // root: both children at stage 2 slot 4/5
        wnode(1, 2, 4, 0, 1, 0, 3, 7, 0);   // prefix 0: left only -> stage 3 slot 7
        wnode(1, 3, 7, 1, 0, 0, 0, 0, 30);  // prefix 00
        wnode(1, 2, 5, 1, 0, 1, 3, 2, 20);  // prefix 1: right only -> stage 3 slot 2+0
        wnode(1, 3, 2, 1, 1, 0, 0, 0, 40);  // prefix 11: left points backward
        wnode(1, 1, 4, 1, 1, 1, 2, 0, 99);  // decoy in skipped stage
        wnode(1, 1, 5, 1, 1, 1, 2, 0, 98);  // decoy in skipped stage

        // Back-to-back lookups, results in order (R2)
        lookup({2'b01, 2'b00, 28'h0}, 1'b0, 30, "R6 R5 R3 deepest 00");
        lookup({2'b01, 2'b01, 28'hFFFFFFF}, 1'b0, 10, "R7 missing right child");
        lookup({2'b01, 2'b10, 28'h0}, 1'b0, 20, "R4 right at base+1 then R7");
        lookup({2'b01, 3'b110, 27'h0}, 1'b0, 40, "R4 right at base+0, R7 backward");
        lookup({2'b10, 30'h0}, 1'b1, 0, "R1 pipe2 still empty");
        idle(LATENCY + 2);

        // R9: writes visible to later lookups, other pipelines unaffected
        wnode(2, 0, 0, 1, 0, 0, 0, 0, 55);
        lookup({2'b10, 30'h3FFFFFFF}, 1'b0, 55, "R9 pipe2 root");
        lookup({2'b01, 2'b00, 28'h0}, 1'b0, 30, "R9 pipe1 untouched");
        lookup({2'b00, 30'h0}, 1'b1, 0, "R9 pipe0 untouched");
        idle(LATENCY + 2);
        wnode(1, 3, 7, 1, 0, 0, 0, 0, 31);
        lookup({2'b01, 2'b00, 28'h0}, 1'b0, 31, "R9 rewritten node");
        // R6: removing the deep next hop falls back to the root's
        idle(LATENCY + 2);
        wnode(1, 3, 7, 0, 0, 0, 0, 0, 0);
        lookup({2'b01, 2'b00, 28'h0}, 1'b0, 10, "R6 fallback to root");
        idle(LATENCY + 2);

        check("R2 queue drained", q.size(), 0);
        check("R1 lanes idle", int'(res_valid), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule